// File: doc/BRIEF.md
# Received-Frame CRC Statistics Counters

This block keeps statistics on frames arriving from the media side of a link. An upstream checker has already computed each frame's CRC. It reports the end of every frame with a one-cycle strobe, together with a flag that says whether the frame check sequence matched.

The block sorts each frame into one of two counters:

- A good-frame counter, which rolls over as a four-digit decimal tally.
- An error-frame counter, which sticks at its ceiling.

A sticky "frame seen" flag is also raised on every frame. Software or a management engine reads these items through a small read port. Every read returns the value held before the read and clears what it returned, so successive reads give the counts since the previous read.

The frame strobe is a valid-only stream with no ready. The block accepts a strobe on every cycle in which it is high and never applies back-pressure. Upstream logic may therefore send a strobe at any time that respects the minimum spacing. The read port is plain control: a request is a single-cycle pulse, and the result comes back one clock later with an acknowledge.

Top module: `crcstat_top`

## Requirements
- R1: Each strobe with the CRC-ok input high adds one to the 14-bit good-frame counter. From the value 9999, the next good frame returns the counter to 0, and counting then continues upward.
- R2: Each strobe with the CRC-ok input low adds one to the 8-bit error-frame counter. The counter stops at 255, and further bad frames leave it at 255.
- R3: Each strobe changes exactly one of the two counters, except when the error counter is already saturated. Strobes are one cycle wide and are separated by at least one idle cycle.
- R4: Any strobe, good or bad, sets the frame-seen flag. The flag stays set until a read with select 0 clears it.
- R5: A request with select 0 returns the frame-seen flag on bit 15, 0 on bit 14 and the good count on bits 13:0. A request with select 1 returns the error count on bits 7:0, with bits 15:8 at 0. The acknowledge rises on the cycle after the request, and the word carries the values from before the request edge. The request clears the selected item: select 0 clears both the good count and the flag, and select 1 clears the error count.
- R6: A frame strobe may land in the same cycle as a read of the item it updates. In that case the read returns the old value, and afterwards the counter holds 1 (and the flag holds 1), so the frame is not lost.
- R7: A synchronous active-high reset clears both counters, the flag, the acknowledge and the read word.
- R8: In any cycle without an acknowledge, the acknowledge is low and the read word is all zero.
- R9: A read of one select leaves the items of the other select unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frm_valid | input | 1 | One-cycle end-of-frame strobe; always accepted |
| frm_crc_ok | input | 1 | CRC result for the strobed frame, 1 = good |
| rd_req | input | 1 | One-cycle read request |
| rd_sel | input | 1 | 0 = good count and flag, 1 = error count |
| rd_ack | output | 1 | Read result valid, one cycle after the request |
| rd_word | output | 16 | Read result; zero when no acknowledge |

## Verification
The assertions assume that frame strobes never arrive on two consecutive cycles and that a read request is a single-cycle pulse with a settled select. One property checks the strobe spacing directly, so a stimulus that breaks it is flagged rather than silently miscounted.

The bench drives every strobe and every request at the falling edge, holds each for exactly one cycle, and always follows it with an idle cycle. Collisions between reads and strobes are created on purpose within that rule. Long runs of good frames reach the decimal rollover, and long runs of bad frames push the error counter into saturation.

// File: rtl/crcstat_pkg.sv
package crcstat_pkg;
  // Read select encoding, fixed by the register layout
  typedef enum logic {
    SEL_GOOD = 1'b0,
    SEL_ERR  = 1'b1
  } rd_sel_e;

  localparam int GOOD_W    = 14;
  localparam int GOOD_LAST = 9999;
  localparam int ERR_W     = 8;
  localparam int ERR_LAST  = 255;
  localparam int WORD_W    = 16;
  localparam int FLAG_POS  = 15;
endpackage

// File: rtl/crcstat_counter.sv
module crcstat_counter #(
  parameter int W        = 14,
  parameter int LAST     = 9999,
  parameter bit SATURATE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] count
);
  timeunit 1ns; timeprecision 1ps;

  localparam logic [W-1:0] LAST_V = W'(LAST);
  localparam logic [W-1:0] ONE_V  = W'(1);

  logic [W-1:0] nxt;
  logic         at_last;

  assign at_last = (count == LAST_V);

  // The parameter picks between a rolling and a sticking ceiling
  generate
    if (SATURATE) begin : g_sat
      always_comb nxt = at_last ? count : count + ONE_V;
    end else begin : g_wrap
      always_comb nxt = at_last ? '0 : count + ONE_V;
    end
  endgenerate

  // A read clear that meets an increment leaves one event behind
  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (clr)  count <= inc ? ONE_V : '0;
    else if (inc)  count <= nxt;
  end
endmodule

// File: rtl/crcstat_flag.sv
module crcstat_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  timeunit 1ns; timeprecision 1ps;

  always_ff @(posedge clk) begin
    if (rst)       flag <= 1'b0;
    else if (set)  flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end
endmodule

// File: rtl/crcstat_rdport.sv
module crcstat_rdport
  import crcstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  rd_sel_e           rd_sel,
  input  logic [GOOD_W-1:0] good_cnt,
  input  logic              rx_flag,
  input  logic [ERR_W-1:0]  err_cnt,
  output logic              rd_ack,
  output logic [WORD_W-1:0] rd_word
);
  timeunit 1ns; timeprecision 1ps;

  logic [WORD_W-1:0] good_word;
  logic [WORD_W-1:0] err_word;
  logic [WORD_W-1:0] sel_word;

  always_comb begin
    good_word           = '0;
    good_word[GOOD_W-1:0] = good_cnt;
    good_word[FLAG_POS] = rx_flag;
    err_word            = '0;
    err_word[ERR_W-1:0] = err_cnt;
    sel_word            = (rd_sel == SEL_ERR) ? err_word : good_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ack  <= 1'b0;
      rd_word <= '0;
    end else begin
      rd_ack  <= rd_req;
      rd_word <= rd_req ? sel_word : '0;
    end
  end
endmodule

// File: rtl/crcstat_top.sv
module crcstat_top
  import crcstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_valid,
  input  logic              frm_crc_ok,
  input  logic              rd_req,
  input  logic              rd_sel,
  output logic              rd_ack,
  output logic [WORD_W-1:0] rd_word
);
  timeunit 1ns; timeprecision 1ps;

  rd_sel_e           sel;
  logic              good_inc, bad_inc;
  logic              good_clr, err_clr;
  logic [GOOD_W-1:0] good_cnt;
  logic [ERR_W-1:0]  err_cnt;
  logic              rx_flag;

  assign sel      = rd_sel_e'(rd_sel);
  assign good_inc = frm_valid &  frm_crc_ok;
  assign bad_inc  = frm_valid & ~frm_crc_ok;
  assign good_clr = rd_req & (sel == SEL_GOOD);
  assign err_clr  = rd_req & (sel == SEL_ERR);

  crcstat_counter #(.W(GOOD_W), .LAST(GOOD_LAST), .SATURATE(1'b0)) u_good (
    .clk(clk), .rst(rst), .inc(good_inc), .clr(good_clr), .count(good_cnt));

  crcstat_counter #(.W(ERR_W), .LAST(ERR_LAST), .SATURATE(1'b1)) u_err (
    .clk(clk), .rst(rst), .inc(bad_inc), .clr(err_clr), .count(err_cnt));

  crcstat_flag u_flag (
    .clk(clk), .rst(rst), .set(frm_valid), .clr(good_clr), .flag(rx_flag));

  crcstat_rdport u_rd (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_sel(sel),
    .good_cnt(good_cnt), .rx_flag(rx_flag), .err_cnt(err_cnt),
    .rd_ack(rd_ack), .rd_word(rd_word));
endmodule

// File: rtl/crcstat_chk.sv
module crcstat_chk
  import crcstat_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              frm_valid,
  input logic              frm_crc_ok,
  input logic              rd_req,
  input logic              rd_sel,
  input logic              rd_ack,
  input logic [WORD_W-1:0] rd_word,
  input logic [GOOD_W-1:0] good_cnt,
  input logic [ERR_W-1:0]  err_cnt,
  input logic              rx_flag
);
  timeunit 1ns; timeprecision 1ps;

  localparam logic [GOOD_W-1:0] GL = GOOD_W'(GOOD_LAST);
  localparam logic [ERR_W-1:0]  EL = ERR_W'(ERR_LAST);

  AST_GOOD_BOUND: assert property (@(posedge clk) disable iff (rst)
    good_cnt <= GL); // R1
  AST_GOOD_WRAP: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && frm_crc_ok && !(rd_req && !rd_sel) && good_cnt == GL) |=> good_cnt == '0); // R1
  AST_ERR_SAT: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && !frm_crc_ok && !(rd_req && rd_sel) && err_cnt == EL) |=> err_cnt == EL); // R2
  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && !rd_req && err_cnt != EL) |=> ($stable(good_cnt) != $stable(err_cnt))); // R3
  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (rst)
    frm_valid |=> !frm_valid); // R3
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    frm_valid |=> rx_flag); // R4
  AST_RD_ACK: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_ack); // R5
  AST_CLR_GOOD: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_sel && !frm_valid) |=> (good_cnt == '0 && !rx_flag)); // R5
  AST_COLLIDE: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_sel && frm_valid && frm_crc_ok) |=> (good_cnt == GOOD_W'(1) && rx_flag)); // R6
  AST_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_ack); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_ack |-> rd_word == '0); // R8
  AST_ERR_KEEP: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_sel && !frm_valid) |=> $stable(good_cnt)); // R9
endmodule

bind crcstat_top crcstat_chk u_chk (
  .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_crc_ok(frm_crc_ok),
  .rd_req(rd_req), .rd_sel(rd_sel), .rd_ack(rd_ack), .rd_word(rd_word),
  .good_cnt(good_cnt), .err_cnt(err_cnt), .rx_flag(rx_flag));

// File: tb/test_crcstat_top.sv
module test_crcstat_top;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frm_valid = 1'b0, frm_crc_ok = 1'b0, rd_req = 1'b0, rd_sel = 1'b0;
  logic        rd_ack;
  logic [15:0] rd_word;

  int    n_chk = 0, n_err = 0;
  bit    armed = 0, done = 0;
  string tag = "R7";
  int    m_good = 0, m_err = 0, m_flag = 0, e_ack = 0, e_word = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  crcstat_top i_crcstat_top (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_crc_ok(frm_crc_ok),
    .rd_req(rd_req), .rd_sel(rd_sel), .rd_ack(rd_ack), .rd_word(rd_word));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_good = 0; m_err = 0; m_flag = 0; e_ack = 0; e_word = 0;
      armed = 1;
    end else begin
      e_ack  = rd_req;
      e_word = !rd_req ? 0 : (rd_sel ? m_err : (m_flag * 32768 + m_good));
      if (rd_req && !rd_sel) begin
        m_good = (frm_valid && frm_crc_ok) ? 1 : 0;
        m_flag = frm_valid ? 1 : 0;
      end else begin
        if (frm_valid && frm_crc_ok) m_good = (m_good == 9999) ? 0 : m_good + 1;
        if (frm_valid) m_flag = 1;
      end
      if (rd_req && rd_sel) m_err = (frm_valid && !frm_crc_ok) ? 1 : 0;
      else if (frm_valid && !frm_crc_ok && m_err < 255) m_err = m_err + 1;
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    if (armed && !done) begin
      chk(rd_ack === e_ack[0], (e_ack != 0) ? "R5" : "R8", int'(rd_ack), e_ack);
      chk(rd_word === e_word[15:0], tag, int'(rd_word), e_word);
    end
  end

  task automatic drive(input bit v, input bit ok, input bit rq, input bit sel);
    @(negedge clk);
    frm_valid = v; frm_crc_ok = ok; rd_req = rq; rd_sel = sel;
  endtask
  task automatic gap();
    drive(0, 0, 0, 0);
  endtask
  task automatic frame(input bit ok);
    drive(1, ok, 0, 0); gap();
  endtask
  task automatic rd(input bit sel);
    drive(0, 0, 1, sel); gap();
  endtask
  task automatic both(input bit ok, input bit sel);
    drive(1, ok, 1, sel); gap();
  endtask

  task automatic summary();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    #900000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R7"; rst = 1'b0;
    rd(0); rd(1);
    tag = "R8"; repeat (4) gap();
    tag = "R1"; repeat (3) frame(1);
    tag = "R2"; repeat (2) frame(0);
    tag = "R5"; rd(0); rd(1); rd(0); rd(1);
    tag = "R4"; frame(0); rd(0); rd(0);
    tag = "R6"; frame(1); frame(1); both(1, 0); rd(0);
    frame(0); both(0, 1); rd(1); rd(1);
    both(0, 0); rd(0); rd(1);
    tag = "R9"; repeat (3) frame(1); repeat (2) frame(0); rd(1); rd(0);
    frame(0); frame(1); rd(0); rd(1);
    tag = "R1"; repeat (9999) frame(1); rd(0);
    repeat (10002) frame(1); rd(0);
    tag = "R2"; repeat (300) frame(0); rd(1); rd(1);
    tag = "R3"; for (int i = 0; i < 40; i++) frame(i % 3 == 0); rd(0); rd(1);
    tag = "R7"; repeat (5) frame(1); frame(0);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk(rd_ack === 1'b0 && rd_word === 16'h0, "R7", int'(rd_word), 0);
    rd(0); rd(1);
    repeat (3) gap();
    summary();
    $finish;
  end
endmodule